// File: doc/BRIEF.md
# Converter serial command and register port

This block is the serial slave that fronts the control registers of a multi-channel converter. A host drives a serial clock and a data line. The block samples both with its own system clock, detects the edges of the serial clock, and shifts bytes in most significant bit first. After power-up the port stays silent until it sees a resynchronisation pattern. That pattern is fifteen bytes of all ones followed by the byte 0xFE, and it may start at any bit alignment. The port then waits for command bytes.

A command byte selects a register group, a channel index and a direction. A 24-bit word follows the command at once. Write data is taken from the data input. Read data comes out on the data output, changing on the falling edges of the serial clock. The register file holds a per-channel offset word and gain word, one setup word per channel (each packing two 12-bit setups), and a configuration word. Two bits of the configuration word give a two-phase software reset and a sticky reset-valid flag.

Top module: `convSerialPort`

## Requirements
- R1: After the hardware reset the port ignores all traffic until it sees at least 127 consecutive ones followed by a zero, which is 15 bytes of 0xFF and then 0xFE, at any bit alignment. Ones are counted only while no word transfer is in progress. A later resynchronisation keeps all register contents.
- R2: Command byte layout: bit 7 selects the direction (1 read, 0 write). Bits 6:5 select the group: 00 configuration, 01 offset, 10 gain, 11 setup. Bits 2:0 give the index. Bits 4:3 are ignored. The bytes 0xFF and 0xFE are fill and start no transfer.
- R3: A 24-bit word follows the command byte directly. Bits are sampled on rising serial clock edges, most significant bit first. After the 24th bit the port waits for a new command.
- R4: For a read, the most significant data bit appears on `sdo` at the first falling edge after the last command bit, and each later falling edge presents the next bit. `sdo` changes only after falling edges and is 0 outside a read word.
- R5: Offset, gain and setup registers exist for index 0 to NUM_CH-1 and read back what was written. A write to a higher index is ignored, and a read from a higher index returns 0.
- R6: After reset the configuration reads 0x000040, offsets 0x000000, gains 0x400000 and setups 0x000000.
- R7: Writing configuration bit 7 = 1 returns every register to its reset value, and the configuration then reads 0x0000C0. While bit 7 stays 1, writes to offset, gain and setup registers are ignored.
- R8: While configuration bit 7 is 1, a configuration write changes only bit 7 and discards all other data bits. Clearing bit 7 therefore leaves the configuration at 0x000040.
- R9: Configuration bit 6 (reset valid) is 1 after any reset and cannot be written. It clears after a configuration read made while bit 7 is 0, and it stays 1 while bit 7 is 1.
- R10: Inside a word transfer every bit is data. A word of 0xFFFFFF is stored as written and causes no fill or resynchronisation handling.
- R11: With bit 7 at 0, configuration bits 23:8 and 5:0 are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host, sampled on rising `sclk` |
| sdo | output | 1 | Serial read data, updated after falling `sclk` |

## Verification
The bench builds the block with NUM_CH = 4. The 3-bit index field can therefore name indices 4 to 7, which brings the ignored-write and zero-read behaviour of absent channels within reach. The setup group follows the same count, so its out-of-range indices are exercised as well. A reference model of the two-phase reset, the sticky reset-valid flag and every register follows random read and write traffic, and directed sequences cover fill bytes, misaligned resynchronisation and words of all ones.

// File: rtl/convPortPkg.sv
package convPortPkg;
  localparam int WORD_W = 24;
  localparam int CMD_W = 8;
  localparam int IDX_W = 3;
  localparam int RESYNC_BYTES = 15;
  localparam int RESYNC_ONES = RESYNC_BYTES * CMD_W + (CMD_W - 1);
  localparam int RS_BIT = 7;
  localparam int RV_BIT = 6;

  localparam logic [WORD_W-1:0] CFG_RST = 24'h000040;
  localparam logic [WORD_W-1:0] OFF_RST = 24'h000000;
  localparam logic [WORD_W-1:0] GAIN_RST = 24'h400000;
  localparam logic [WORD_W-1:0] SETUP_RST = 24'h000000;

  typedef enum logic [1:0] {GRP_CFG = 2'd0, GRP_OFF = 2'd1, GRP_GAIN = 2'd2, GRP_SETUP = 2'd3} regGrp_e;
  typedef enum logic [1:0] {PORT_UNSYNC = 2'd0, PORT_CMD = 2'd1, PORT_WORD = 2'd2} portState_e;

  typedef struct packed {
    logic dataBit;
    logic shiftBit;
    logic latchCmd;
    logic loadRead;
    logic commitWrite;
    logic shiftRead;
    logic idleOut;
  } portStrobe_t;
endpackage

// File: rtl/portCtrl.sv
module portCtrl
  import convPortPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             sdi,
  output portStrobe_t      stb,
  output regGrp_e          regSel,
  output logic [IDX_W-1:0] regIdx
);
  localparam int BIT_CNT_W = $clog2(WORD_W + 1);
  localparam int ONES_W = $clog2(RESYNC_ONES + 1);
  localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(RESYNC_ONES);
  localparam logic [CMD_W-1:0] FILL_HI = {CMD_W{1'b1}};
  localparam logic [CMD_W-1:0] FILL_LO = {{(CMD_W-1){1'b1}}, 1'b0};

  logic [2:0] sclkQ;
  logic [1:0] sdiQ;
  portState_e state;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [ONES_W-1:0] onesCnt;
  logic [CMD_W-2:0] cmdShift;
  logic cmdRead;
  regGrp_e cmdGrp;
  logic [IDX_W-1:0] cmdIdx;

  logic rise, fall, bitIn, huntZone, resyncHit, byteDone, wordDone, isFill;
  logic [CMD_W-1:0] nextByte;

  always_comb begin
    rise = sclkQ[1] & ~sclkQ[2];
    fall = ~sclkQ[1] & sclkQ[2];
    bitIn = sdiQ[1];
    nextByte = {cmdShift, bitIn};
    huntZone = (state != PORT_WORD);
    resyncHit = rise && huntZone && !bitIn && (onesCnt == ONES_MAX);
    byteDone = (bitCnt == BIT_CNT_W'(CMD_W - 1));
    wordDone = (bitCnt == BIT_CNT_W'(WORD_W - 1));
    isFill = (nextByte == FILL_HI) || (nextByte == FILL_LO);

    stb = '0;
    stb.dataBit = bitIn;
    stb.latchCmd = rise && !resyncHit && (state == PORT_CMD) && byteDone && !isFill;
    stb.loadRead = stb.latchCmd && nextByte[CMD_W-1];
    stb.shiftBit = rise && (state == PORT_WORD);
    stb.commitWrite = stb.shiftBit && wordDone && !cmdRead;
    stb.shiftRead = fall && (state == PORT_WORD) && cmdRead;
    stb.idleOut = fall && !((state == PORT_WORD) && cmdRead);

    regSel = stb.latchCmd ? regGrp_e'(nextByte[6:5]) : cmdGrp;
    regIdx = stb.latchCmd ? nextByte[IDX_W-1:0] : cmdIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= '0;
      sdiQ <= '0;
      state <= PORT_UNSYNC;
      bitCnt <= '0;
      onesCnt <= '0;
      cmdShift <= '0;
      cmdRead <= 1'b0;
      cmdGrp <= GRP_CFG;
      cmdIdx <= '0;
    end else begin
      sclkQ <= {sclkQ[1:0], sclk};
      sdiQ <= {sdiQ[0], sdi};
      if (rise) begin
        if (huntZone && bitIn) onesCnt <= (onesCnt == ONES_MAX) ? onesCnt : onesCnt + 1'b1;
        else onesCnt <= '0;

        if (resyncHit) begin
          state <= PORT_CMD;
          bitCnt <= '0;
        end else begin
          case (state)
            PORT_CMD: begin
              cmdShift <= nextByte[CMD_W-2:0];
              if (byteDone) begin
                bitCnt <= '0;
                if (!isFill) begin
                  cmdRead <= nextByte[CMD_W-1];
                  cmdGrp <= regGrp_e'(nextByte[6:5]);
                  cmdIdx <= nextByte[IDX_W-1:0];
                  state <= PORT_WORD;
                end
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
            PORT_WORD: begin
              if (wordDone) begin
                bitCnt <= '0;
                state <= PORT_CMD;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/portRegs.sv
module portRegs
  import convPortPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_SETUP = NUM_CH
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      stb,
  input  regGrp_e          regSel,
  input  logic [IDX_W-1:0] regIdx,
  output logic             sdo
);
  logic [WORD_W-1:0] offsetReg [NUM_CH];
  logic [WORD_W-1:0] gainReg [NUM_CH];
  logic [WORD_W-1:0] setupReg [NUM_SETUP];
  logic [WORD_W-1:0] cfgReg, inShift, outShift, wdata, rdVal, rsCfg, cfgPlain;
  logic sdoQ, inReset, sysRst, cfgWr;

  always_comb begin
    wdata = {inShift[WORD_W-2:0], stb.dataBit};
    inReset = cfgReg[RS_BIT];
    cfgWr = stb.commitWrite && (regSel == GRP_CFG);
    sysRst = cfgWr && !inReset && wdata[RS_BIT];
    rsCfg = CFG_RST;
    rsCfg[RS_BIT] = wdata[RS_BIT];
    cfgPlain = wdata;
    cfgPlain[RV_BIT] = cfgReg[RV_BIT];

    rdVal = '0;
    case (regSel)
      GRP_CFG: rdVal = cfgReg;
      GRP_OFF: for (int c = 0; c < NUM_CH; c++) if (regIdx == IDX_W'(c)) rdVal = offsetReg[c];
      GRP_GAIN: for (int c = 0; c < NUM_CH; c++) if (regIdx == IDX_W'(c)) rdVal = gainReg[c];
      default: for (int s = 0; s < NUM_SETUP; s++) if (regIdx == IDX_W'(s)) rdVal = setupReg[s];
    endcase
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WORD_W-1:0] offQ, gainQ;
    logic hitIdx;
    assign hitIdx = stb.commitWrite && !inReset && (regIdx == IDX_W'(c));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offQ <= OFF_RST;
        gainQ <= GAIN_RST;
      end else if (sysRst) begin
        offQ <= OFF_RST;
        gainQ <= GAIN_RST;
      end else if (hitIdx && regSel == GRP_OFF) begin
        offQ <= wdata;
      end else if (hitIdx && regSel == GRP_GAIN) begin
        gainQ <= wdata;
      end
    end
    assign offsetReg[c] = offQ;
    assign gainReg[c] = gainQ;
  end

  for (genvar s = 0; s < NUM_SETUP; s++) begin : g_setup
    logic [WORD_W-1:0] setQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) setQ <= SETUP_RST;
      else if (sysRst) setQ <= SETUP_RST;
      else if (stb.commitWrite && !inReset && regSel == GRP_SETUP && regIdx == IDX_W'(s)) setQ <= wdata;
    end
    assign setupReg[s] = setQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= CFG_RST;
      inShift <= '0;
      outShift <= '0;
      sdoQ <= 1'b0;
    end else begin
      if (stb.shiftBit) inShift <= wdata;

      if (cfgWr) begin
        if (inReset || wdata[RS_BIT]) cfgReg <= rsCfg;
        else cfgReg <= cfgPlain;
      end else if (stb.loadRead && regSel == GRP_CFG && !inReset) begin
        cfgReg[RV_BIT] <= 1'b0;
      end

      if (stb.loadRead) begin
        outShift <= rdVal;
      end else if (stb.shiftRead) begin
        sdoQ <= outShift[WORD_W-1];
        outShift <= {outShift[WORD_W-2:0], 1'b0};
      end else if (stb.idleOut) begin
        sdoQ <= 1'b0;
      end
    end
  end

  assign sdo = sdoQ;
endmodule

// File: rtl/convSerialPort.sv
module convSerialPort
  import convPortPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_SETUP = NUM_CH
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);
  portStrobe_t stb;
  regGrp_e regSel;
  logic [IDX_W-1:0] regIdx;

  portCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdi(sdi),
    .stb(stb), .regSel(regSel), .regIdx(regIdx)
  );

  portRegs #(.NUM_CH(NUM_CH), .NUM_SETUP(NUM_SETUP)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel), .regIdx(regIdx), .sdo(sdo)
  );
endmodule

// File: rtl/convSerialPort_chk.sv
module convSerialPort_chk
  import convPortPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sdo,
  input portStrobe_t       stb,
  input logic [1:0]        ctrlState,
  input logic [WORD_W-1:0] cfgQ,
  input logic [WORD_W-1:0] gain0,
  input logic [WORD_W-1:0] off0
);
  assert_sdo_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.shiftRead || stb.idleOut) |-> $stable(sdo));

  assert_rv_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ[RS_BIT] |-> cfgQ[RV_BIT]);

  assert_regs_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ[RS_BIT] |-> (gain0 == GAIN_RST) && (off0 == OFF_RST));

  assert_latch_enters_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchCmd |=> (ctrlState == PORT_WORD));

  assert_commit_leaves_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.commitWrite |=> (ctrlState == PORT_CMD));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.latchCmd, stb.commitWrite, stb.shiftRead, stb.idleOut}));
endmodule

bind convSerialPort convSerialPort_chk u_chk (
  .clk(clk), .rstN(rstN), .sdo(sdo), .stb(stb),
  .ctrlState(u_ctrl.state), .cfgQ(u_dp.cfgReg),
  .gain0(u_dp.gainReg[0]), .off0(u_dp.offsetReg[0])
);

// File: tb/convSerialPort_bench.sv
module convSerialPort_bench;
  localparam int NCH = 4;
  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, sdi = 1'b0;
  wire sdo;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  logic [23:0] mOff [8];
  logic [23:0] mGain [8];
  logic [23:0] mSet [8];
  logic [23:0] mCfg;

  always #10 clk = ~clk;

  convSerialPort #(.NUM_CH(NCH)) u_convSerialPort (.clk(clk), .rstN(rstN), .sclk(sclk), .sdi(sdi), .sdo(sdo));

  task automatic check(string tag, logic [23:0] got, logic [23:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin
      mOff[i] = 24'h0; mGain[i] = 24'h400000; mSet[i] = 24'h0;
    end
    mCfg = 24'h000040;
  endtask

  task automatic modelWrite(logic [1:0] g, logic [2:0] i, logic [23:0] d);
    if (g == 2'd0) begin
      if (mCfg[7] || d[7]) begin
        modelReset();
        mCfg[7] = d[7];
      end else mCfg = {d[23:8], 1'b0, mCfg[6], d[5:0]};
    end else if (!mCfg[7] && i < NCH) begin
      if (g == 2'd1) mOff[i] = d;
      else if (g == 2'd2) mGain[i] = d;
      else mSet[i] = d;
    end
  endtask

  task automatic modelRead(logic [1:0] g, logic [2:0] i, output logic [23:0] v);
    if (g == 2'd0) begin
      v = mCfg;
      if (!mCfg[7]) mCfg[6] = 1'b0;
    end else if (i >= NCH) v = 24'h0;
    else if (g == 2'd1) v = mOff[i];
    else if (g == 2'd2) v = mGain[i];
    else v = mSet[i];
  endtask

  task automatic xferBit(logic b, output logic o);
    @(negedge clk);
    o = sdo;
    sdi = b;
    repeat (5) @(negedge clk);
    sclk = 1'b1;
    repeat (5) @(negedge clk);
    sclk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic sendByte(logic [7:0] b);
    logic o;
    for (int k = 7; k >= 0; k--) xferBit(b[k], o);
  endtask

  task automatic resync();
    for (int k = 0; k < 15; k++) sendByte(8'hFF);
    sendByte(8'hFE);
  endtask

  task automatic sendWord(logic [23:0] d);
    logic o;
    for (int k = 23; k >= 0; k--) xferBit(d[k], o);
  endtask

  task automatic busWrite(logic [1:0] g, logic [2:0] i, logic [23:0] d);
    sendByte({1'b0, g, 2'b00, i});
    sendWord(d);
    modelWrite(g, i, d);
  endtask

  task automatic doRead(logic [1:0] g, logic [2:0] i, string tag);
    logic [23:0] got, exp;
    logic o;
    sendByte({1'b1, g, 2'b00, i});
    for (int k = 23; k >= 0; k--) begin
      xferBit(1'($urandom % 2), o);
      got[k] = o;
    end
    modelRead(g, i, exp);
    check(tag, got, exp);
  endtask

  initial begin
    logic o;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 reset sdo", {23'd0, sdo}, 24'h0);

    // R1: traffic before resync ignored, misaligned pattern accepted
    sendByte(8'h40); sendWord(24'h123456);
    xferBit(1'b1, o); xferBit(1'b0, o); xferBit(1'b1, o);
    resync();
    doRead(2'd2, 3'd0, "R1 pre-sync write ignored / R4 msb first");
    doRead(2'd0, 3'd0, "R6 R9 config reset value");
    doRead(2'd0, 3'd0, "R9 valid flag cleared by read");
    for (int i = 0; i < NCH; i++) begin
      doRead(2'd1, 3'(i), "R6 offset reset");
      doRead(2'd3, 3'(i), "R6 setup reset");
    end

    // R2: fill bytes, ignored bits 4:3
    sendByte(8'hFF);
    busWrite(2'd1, 3'd1, 24'hA5A5A5);
    sendByte(8'hFE);
    doRead(2'd1, 3'd1, "R2 fill bytes skipped / R3");
    sendByte(8'h39); sendWord(24'h5A5A5A); modelWrite(2'd1, 3'd1, 24'h5A5A5A);
    doRead(2'd1, 3'd1, "R2 bits 4:3 ignored");
    check("R4 sdo idle after read", {23'd0, sdo}, 24'h0);

    // R10: all-ones data word
    busWrite(2'd3, 3'd0, 24'hFFFFFF);
    busWrite(2'd2, 3'd1, 24'h13579B);
    doRead(2'd3, 3'd0, "R10 all-ones word stored");
    doRead(2'd2, 3'd1, "R10 alignment kept");

    // R11: plain config storage, valid bit read-only
    busWrite(2'd0, 3'd0, 24'hABCD7F);
    doRead(2'd0, 3'd0, "R11 config storage");

    // R7 / R8 / R9: two-phase reset
    busWrite(2'd0, 3'd0, 24'hFFFF80);
    doRead(2'd0, 3'd0, "R7 config in reset");
    busWrite(2'd2, 3'd1, 24'h777777);
    doRead(2'd2, 3'd1, "R7 write ignored in reset");
    doRead(2'd1, 3'd1, "R7 offset back to reset");
    doRead(2'd0, 3'd0, "R9 valid held in reset");
    busWrite(2'd0, 3'd0, 24'hFFFF7F);
    doRead(2'd0, 3'd0, "R8 other bits discarded");
    doRead(2'd0, 3'd0, "R9 cleared after reset exit");
    busWrite(2'd0, 3'd0, 24'h00FF00);
    doRead(2'd0, 3'd0, "R11 config rewrite");

    // R5: absent channels
    busWrite(2'd1, 3'd5, 24'h111111);
    doRead(2'd1, 3'd5, "R5 absent offset");
    busWrite(2'd3, 3'd6, 24'h222222);
    doRead(2'd3, 3'd6, "R5 absent setup");
    busWrite(2'd2, 3'd3, 24'h0F0F0F);
    doRead(2'd2, 3'd3, "R5 gain top channel");

    for (int n = 0; n < 70; n++) begin
      logic [1:0] g;
      logic [2:0] i;
      logic [23:0] d;
      g = 2'($urandom % 4);
      i = 3'($urandom % 8);
      d = 24'($urandom);
      if (g == 2'd0 && ($urandom % 6) != 0) d[7] = 1'b0;
      if ($urandom % 2) busWrite(g, i, d);
      else doRead(g, i, "R5 random access");
    end

    resync();
    for (int i = 0; i < NCH; i++) doRead(2'd1, 3'(i), "R1 resync keeps registers");
    doRead(2'd0, 3'd0, "R1 resync keeps config");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=%h exp=%h", 24'h0, 24'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule